// File: doc/BRIEF.md
# Chainable Three-Channel Timer Block

This block holds three independent up-counting timer channels behind one small register window, plus two block-wide controls. Each channel picks its count source from the system clock, one of two shared tick strobes (a fast prescaled tick and a slow tick, for example derived from a 32768 Hz source), or the rising edges of an external level. The count source is gated by a clock-enable bit. Each channel has two compare registers. Compare A raises the channel's waveform output, and compare C lowers it. Compare C also sets a sticky flag and emits a one-cycle event pulse. A channel can optionally restart from zero after compare C (periodic use) or switch its clock off there (one-shot use).

At block level, a mode bit sends channel 0's waveform into channel 1's external clock input. With channel 0 set to raise its waveform at count 0 and lower it at 0x8000, channel 1 advances once per full 65536-count lap of channel 0. The pair then reads back as one 32-bit time base. A block control write zeroes all three counters on the same clock edge. When the build parameter for a native 32-bit counter is set, channel 0 is built 32 bits wide and forms the time base on its own.

Addresses are five bits wide: {channel[1:0], register[2:0]}. Channel index 3 selects the block registers. Writes take effect on the clock edge at which wr_en is sampled high. Reads are combinational.

Top module: `tmr_block`

## Requirements
- R1: After reset, every counter, compare register, mode field, status bit, waveform output, event output, the chain bit and the time base are zero.
- R2: Each channel decodes register 0 as mode, 1 as compare A, 2 as compare C, 3 as count (read-only), 4 as status and 5 as control (write-only). Mode bits [1:0] select the count source: 0 = system clock, 1 = tick_fast_i, 2 = tick_slow_i, 3 = rising edges of the external level. Pulses on any unselected source leave the count unchanged.
- R3: Control bit 0 sets the clock enable and control bit 1 clears it; bit 1 wins if both are set. While the enable is clear, the count holds. Status bit 0 reads the enable.
- R4: With mode bit 2 set, the tick that finds the count equal to compare C loads 0, so the count period is C+1 ticks.
- R5: With mode bit 3 set, the tick that brings the count to compare C also clears the clock enable, and the count then holds at C.
- R6: Without mode bit 2, a channel counts freely and wraps from its all-ones value to 0.
- R7: The waveform (status bit 2, wave_o) goes high on a tick whose new count equals compare A, and goes low on a tick whose new count equals compare C. Compare A wins when the two are equal. A trigger clears the waveform.
- R8: A tick whose new count equals compare C sets the sticky flag (status bit 1) and produces exactly one single-cycle evt_o pulse. A trigger clears the flag.
- R9: Control bit 2 (trigger) loads 0 into the channel's count on the next edge.
- R10: Writing 1 in bit 0 of block register 0 (channel index 3) zeroes all three counters on the same edge and leaves every clock enable as it was.
- R11: Block register 1 bit 0 (readable) routes channel 0's waveform into channel 1's external input. Block register 2 and timebase_o return {channel 1 count[15:0], channel 0 count[15:0]}. With channel 0 set to A=0, C=0x8000 and no auto-restart, 65541 channel 0 ticks give 0x0001_0005.
- R12: With NATIVE32=1, channel 0 counts 32 bits wide, and both block register 2 and timebase_o return channel 0's count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | {channel, register} address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data |
| tick_fast_i | input | 1 | Shared fast count strobe |
| tick_slow_i | input | 1 | Shared slow count strobe |
| ext_clk_i | input | 3 | Per-channel external count level |
| wave_o | output | 3 | Per-channel waveform |
| evt_o | output | 3 | Per-channel compare C event pulse |
| timebase_o | output | 32 | Combined free-running count |

## Verification
The hardest situation to reach is the carry of the chained pair: channel 1 moves only after channel 0 has run through all 65536 states and its waveform has risen at the wrap. Landing on an exact expected value therefore needs an exact tick count. The stimulus puts channel 0 on the fast tick strobe and holds that strobe high for exactly 65541 cycles. A 16-bit instance and a native 32-bit instance receive the same inputs in parallel, so the same number must appear both as the chained time base and as the single wide count.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int DATA_W    = 32;
  localparam int CH_SEL_W  = 2;
  localparam int REG_SEL_W = 3;
  localparam int NUM_CH    = 3;
  localparam int ADDR_W    = CH_SEL_W + REG_SEL_W;

  typedef enum logic [1:0] {
    SRC_SYS  = 2'd0,
    SRC_FAST = 2'd1,
    SRC_SLOW = 2'd2,
    SRC_EXT  = 2'd3
  } clk_src_e;

  // channel register indices
  localparam logic [REG_SEL_W-1:0] REG_MODE   = 3'd0;
  localparam logic [REG_SEL_W-1:0] REG_CMPA   = 3'd1;
  localparam logic [REG_SEL_W-1:0] REG_CMPC   = 3'd2;
  localparam logic [REG_SEL_W-1:0] REG_COUNT  = 3'd3;
  localparam logic [REG_SEL_W-1:0] REG_STATUS = 3'd4;
  localparam logic [REG_SEL_W-1:0] REG_CTRL   = 3'd5;

  // block registers live at channel index 3
  localparam logic [CH_SEL_W-1:0]  BLK_CH     = 2'd3;
  localparam logic [REG_SEL_W-1:0] BREG_CTL   = 3'd0;
  localparam logic [REG_SEL_W-1:0] BREG_MODE  = 3'd1;
  localparam logic [REG_SEL_W-1:0] BREG_TBASE = 3'd2;

  localparam int CTL_START = 0;
  localparam int CTL_STOP  = 1;
  localparam int CTL_TRIG  = 2;
  localparam int MODE_AUTO = 2;
  localparam int MODE_HALT = 3;
  localparam int MODE_W    = 4;

  // count after one tick, for a counter w bits wide
  function automatic logic [DATA_W-1:0] next_count(
    input logic [DATA_W-1:0] cnt,
    input logic [DATA_W-1:0] cmpc,
    input logic              auto_rst,
    input int                w
  );
    logic [DATA_W-1:0] mask;
    mask = (w >= DATA_W) ? '1 : ((DATA_W'(1) << w) - DATA_W'(1));
    if (auto_rst && (cnt == cmpc)) return '0;
    return (cnt + DATA_W'(1)) & mask;
  endfunction
endpackage

// File: rtl/tmr_edge_det.sv
`timescale 1ns/1ps
module tmr_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/tmr_chan.sv
`timescale 1ns/1ps
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_i,
  input  logic              mode_we,
  input  logic              cmpa_we,
  input  logic              cmpc_we,
  input  logic              ctl_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              fast_tick_i,
  input  logic              slow_tick_i,
  input  logic              ext_lvl_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic [DATA_W-1:0] cmpa_o,
  output logic [DATA_W-1:0] cmpc_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              clken_o,
  output logic              flag_o,
  output logic              wave_o,
  output logic              evt_o,
  output logic              trig_o
);
  logic [W-1:0]      cnt_q, cmpa_q, cmpc_q, nxt;
  logic [MODE_W-1:0] mode_q;
  logic              clken_q, flag_q, wave_q, evt_q;
  logic              ext_rise, src_tick, tick, trig, hit_a, hit_c;
  clk_src_e          src;

  tmr_edge_det u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl_i (ext_lvl_i),
    .rise_o(ext_rise)
  );

  assign src = clk_src_e'(mode_q[1:0]);

  always_comb begin
    unique case (src)
      SRC_SYS:  src_tick = 1'b1;
      SRC_FAST: src_tick = fast_tick_i;
      SRC_SLOW: src_tick = slow_tick_i;
      default:  src_tick = ext_rise;
    endcase
  end

  assign tick  = clken_q & src_tick;
  assign trig  = ctl_we & wdata[CTL_TRIG];
  assign nxt   = W'(next_count(DATA_W'(cnt_q), DATA_W'(cmpc_q), mode_q[MODE_AUTO], W));
  assign hit_a = (nxt == cmpa_q);
  assign hit_c = (nxt == cmpc_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      cmpa_q  <= '0;
      cmpc_q  <= '0;
      mode_q  <= '0;
      clken_q <= 1'b0;
      flag_q  <= 1'b0;
      wave_q  <= 1'b0;
      evt_q   <= 1'b0;
    end else begin
      evt_q <= 1'b0;
      if (mode_we) mode_q <= wdata[MODE_W-1:0];
      if (cmpa_we) cmpa_q <= wdata[W-1:0];
      if (cmpc_we) cmpc_q <= wdata[W-1:0];

      if (sync_i || trig) begin
        cnt_q <= '0;
      end else if (tick) begin
        cnt_q <= nxt;
        if (hit_a)      wave_q <= 1'b1;
        else if (hit_c) wave_q <= 1'b0;
        if (hit_c) begin
          flag_q <= 1'b1;
          evt_q  <= 1'b1;
          if (mode_q[MODE_HALT]) clken_q <= 1'b0;
        end
      end

      if (trig) begin
        flag_q <= 1'b0;
        wave_q <= 1'b0;
      end

      if (ctl_we && wdata[CTL_STOP])       clken_q <= 1'b0;
      else if (ctl_we && wdata[CTL_START]) clken_q <= 1'b1;
    end
  end

  assign cnt_o   = DATA_W'(cnt_q);
  assign cmpa_o  = DATA_W'(cmpa_q);
  assign cmpc_o  = DATA_W'(cmpc_q);
  assign mode_o  = mode_q;
  assign clken_o = clken_q;
  assign flag_o  = flag_q;
  assign wave_o  = wave_q;
  assign evt_o   = evt_q;
  assign trig_o  = trig;
endmodule

// File: rtl/tmr_block.sv
`timescale 1ns/1ps
module tmr_block
  import tmr_pkg::*;
#(
  parameter bit NATIVE32 = 1'b0,
  parameter int CNT_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              tick_fast_i,
  input  logic              tick_slow_i,
  input  logic [NUM_CH-1:0] ext_clk_i,
  output logic [NUM_CH-1:0] wave_o,
  output logic [NUM_CH-1:0] evt_o,
  output logic [DATA_W-1:0] timebase_o
);
  logic [CH_SEL_W-1:0]  sel_ch;
  logic [REG_SEL_W-1:0] sel_reg;
  logic                 sync_pulse, chain_en, blk_mode_we;

  logic [NUM_CH-1:0] ch_wave, ch_clken, ch_flag, ch_evt, ch_trig, ch_ctl_we;
  logic [NUM_CH-1:0][DATA_W-1:0] ch_cnt, ch_cmpa, ch_cmpc;
  logic [NUM_CH-1:0][MODE_W-1:0] ch_mode;

  assign sel_ch      = addr[ADDR_W-1:REG_SEL_W];
  assign sel_reg     = addr[REG_SEL_W-1:0];
  assign sync_pulse  = wr_en && (sel_ch == BLK_CH) && (sel_reg == BREG_CTL) && wdata[0];
  assign blk_mode_we = wr_en && (sel_ch == BLK_CH) && (sel_reg == BREG_MODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           chain_en <= 1'b0;
    else if (blk_mode_we) chain_en <= wdata[0];
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam int W = (i == 0 && NATIVE32) ? 2 * CNT_W : CNT_W;
    logic hit, ext_lvl;

    assign hit          = wr_en && (sel_ch == CH_SEL_W'(i));
    assign ch_ctl_we[i] = hit && (sel_reg == REG_CTRL);

    if (i == 1) begin : g_chain
      assign ext_lvl = chain_en ? ch_wave[0] : ext_clk_i[1];
    end else begin : g_plain
      assign ext_lvl = ext_clk_i[i];
    end

    tmr_chan #(.W(W)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .sync_i     (sync_pulse),
      .mode_we    (hit && (sel_reg == REG_MODE)),
      .cmpa_we    (hit && (sel_reg == REG_CMPA)),
      .cmpc_we    (hit && (sel_reg == REG_CMPC)),
      .ctl_we     (ch_ctl_we[i]),
      .wdata      (wdata),
      .fast_tick_i(tick_fast_i),
      .slow_tick_i(tick_slow_i),
      .ext_lvl_i  (ext_lvl),
      .cnt_o      (ch_cnt[i]),
      .cmpa_o     (ch_cmpa[i]),
      .cmpc_o     (ch_cmpc[i]),
      .mode_o     (ch_mode[i]),
      .clken_o    (ch_clken[i]),
      .flag_o     (ch_flag[i]),
      .wave_o     (ch_wave[i]),
      .evt_o      (ch_evt[i]),
      .trig_o     (ch_trig[i])
    );
  end

  if (NATIVE32) begin : g_tb_wide
    assign timebase_o = ch_cnt[0];
  end else begin : g_tb_pair
    assign timebase_o = DATA_W'({ch_cnt[1][CNT_W-1:0], ch_cnt[0][CNT_W-1:0]});
  end

  always_comb begin
    rdata = '0;
    if (sel_ch == BLK_CH) begin
      case (sel_reg)
        BREG_MODE:  rdata[0] = chain_en;
        BREG_TBASE: rdata = timebase_o;
        default:    rdata = '0;
      endcase
    end else begin
      case (sel_reg)
        REG_MODE:   rdata = DATA_W'(ch_mode[sel_ch]);
        REG_CMPA:   rdata = ch_cmpa[sel_ch];
        REG_CMPC:   rdata = ch_cmpc[sel_ch];
        REG_COUNT:  rdata = ch_cnt[sel_ch];
        REG_STATUS: rdata = DATA_W'({ch_wave[sel_ch], ch_flag[sel_ch], ch_clken[sel_ch]});
        default:    rdata = '0;
      endcase
    end
  end

  assign wave_o = ch_wave;
  assign evt_o  = ch_evt;
endmodule

// File: rtl/tmr_block_chk.sv
`timescale 1ns/1ps
module tmr_block_chk (
  input logic             clk,
  input logic             rst_n,
  input logic             sync_pulse,
  input logic             chain_en,
  input logic [2:0]       ch_wave,
  input logic [2:0]       ch_clken,
  input logic [2:0]       ch_flag,
  input logic [2:0]       ch_evt,
  input logic [2:0]       ch_trig,
  input logic [2:0]       ch_ctl_we,
  input logic [2:0][3:0]  ch_mode,
  input logic [2:0][31:0] ch_cnt
);
  // R10
  sync_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse |=> (ch_cnt[0] == 32'd0 && ch_cnt[1] == 32'd0 && ch_cnt[2] == 32'd0));

  // R10
  sync_keep_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse |=> (ch_clken == $past(ch_clken)));

  // R11
  chain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ch_wave[0]) && chain_en && $past(chain_en) && ch_clken[1] &&
     ch_mode[1][1:0] == 2'd3 && !sync_pulse && !ch_trig[1])
    |=> (ch_cnt[1][15:0] == $past(ch_cnt[1][15:0]) + 16'd1));

  for (genvar i = 0; i < 3; i++) begin : g_chk
    // R3
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ch_clken[i] && !sync_pulse && !ch_trig[i]) |=> $stable(ch_cnt[i]));

    // R8
    evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch_evt[i] |-> ch_flag[i]);

    // R5
    halt_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_evt[i] && $past(ch_mode[i][3]) && !$past(ch_ctl_we[i])) |-> !ch_clken[i]);
  end
endmodule

bind tmr_block tmr_block_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .sync_pulse(sync_pulse),
  .chain_en  (chain_en),
  .ch_wave   (ch_wave),
  .ch_clken  (ch_clken),
  .ch_flag   (ch_flag),
  .ch_evt    (ch_evt),
  .ch_trig   (ch_trig),
  .ch_ctl_we (ch_ctl_we),
  .ch_mode   (ch_mode),
  .ch_cnt    (ch_cnt)
);

// File: tb/tmr_block_tb_top.sv
`timescale 1ns/1ps
module tmr_block_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        tick_fast = 1'b0;
  logic        tick_slow = 1'b0;
  logic [2:0]  ext_clk = '0;
  logic [31:0] rdata, rdata32, tbase, tbase32;
  logic [2:0]  wave, wave32, evt, evt32;

  int checks = 0;
  int failures = 0;
  int evt_cnt = 0;
  bit timeout = 1'b0;

  always #2.5 clk = ~clk;

  tmr_block #(.NATIVE32(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .tick_fast_i(tick_fast), .tick_slow_i(tick_slow), .ext_clk_i(ext_clk),
    .wave_o(wave), .evt_o(evt), .timebase_o(tbase)
  );

  tmr_block #(.NATIVE32(1'b1)) dut32_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata32),
    .tick_fast_i(tick_fast), .tick_slow_i(tick_slow), .ext_clk_i(ext_clk),
    .wave_o(wave32), .evt_o(evt32), .timebase_o(tbase32)
  );

  always @(posedge clk) if (evt[2]) evt_cnt <= evt_cnt + 1;

  // vector: mode, compare A, compare C, slow ticks, expected count, status, events
  typedef struct packed {
    logic [3:0]  mode;
    logic [15:0] cmpa;
    logic [15:0] cmpc;
    logic [7:0]  n;
    logic [15:0] cnt;
    logic [2:0]  st;
    logic [3:0]  evts;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{4'b0110, 16'd2, 16'd5, 8'd3,  16'd3, 3'b101, 4'd0},
    '{4'b0110, 16'd2, 16'd5, 8'd6,  16'd0, 3'b011, 4'd1},
    '{4'b0110, 16'd2, 16'd5, 8'd8,  16'd2, 3'b111, 4'd1},
    '{4'b1010, 16'd1, 16'd4, 8'd10, 16'd4, 3'b010, 4'd1},
    '{4'b0010, 16'd0, 16'd3, 8'd5,  16'd5, 3'b011, 4'd1},
    '{4'b1110, 16'd0, 16'd2, 8'd5,  16'd2, 3'b010, 4'd1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] ch, input logic [2:0] rg, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = {ch, rg}; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] ch, input logic [2:0] rg, output logic [31:0] d);
    @(negedge clk);
    addr = {ch, rg};
    #1 d = rdata;
  endtask

  task automatic slow_pulses(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) tick_slow = 1'b1;
      @(negedge clk) tick_slow = 1'b0;
    end
  endtask

  task automatic fast_pulses(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) tick_fast = 1'b1;
      @(negedge clk) tick_fast = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_all();
    logic [31:0] v;
    int e0;

    do_reset();
    // R1 reset state
    rd(2'd0, 3'd3, v); chk("R1 ch0 count", v, 32'd0);
    rd(2'd2, 3'd4, v); chk("R1 ch2 status", v, 32'd0);
    rd(2'd1, 3'd2, v); chk("R1 ch1 cmpC", v, 32'd0);
    rd(2'd3, 3'd1, v); chk("R1 chain bit", v, 32'd0);
    chk("R1 timebase", tbase, 32'd0);
    chk("R1 wave/evt", {26'd0, wave, evt}, 32'd0);

    // R4 R5 R6 R7 R8 vector table on channel 2, slow tick source
    foreach (VECS[j]) begin
      wr(2'd2, 3'd0, 32'(VECS[j].mode));
      wr(2'd2, 3'd1, 32'(VECS[j].cmpa));
      wr(2'd2, 3'd2, 32'(VECS[j].cmpc));
      wr(2'd2, 3'd5, 32'h5);
      e0 = evt_cnt;
      slow_pulses(int'(VECS[j].n));
      repeat (3) @(negedge clk);
      rd(2'd2, 3'd3, v); chk($sformatf("R4/R5/R6 vec%0d count", j), v, 32'(VECS[j].cnt));
      rd(2'd2, 3'd4, v); chk($sformatf("R7/R5 vec%0d status", j), v, 32'(VECS[j].st));
      chk($sformatf("R8 vec%0d events", j), 32'(evt_cnt - e0), 32'(VECS[j].evts));
    end

    // R2 unselected source ignored, selected counted
    wr(2'd2, 3'd2, 32'hFFFF);
    wr(2'd2, 3'd0, 32'h2);
    wr(2'd2, 3'd5, 32'h5);
    fast_pulses(5);
    rd(2'd2, 3'd3, v); chk("R2 fast ignored", v, 32'd0);
    slow_pulses(2);
    rd(2'd2, 3'd3, v); chk("R2 slow counted", v, 32'd2);
    // R3 disabled channel holds
    wr(2'd2, 3'd5, 32'h3);
    rd(2'd2, 3'd4, v); chk("R3 stop wins", v & 32'h1, 32'd0);
    slow_pulses(3);
    rd(2'd2, 3'd3, v); chk("R3 hold while off", v, 32'd2);
    // R9 trigger
    wr(2'd2, 3'd5, 32'h4);
    rd(2'd2, 3'd3, v); chk("R9 trigger zeroes", v, 32'd0);

    // R10 sync across channels running on system clock
    for (int c = 0; c < 3; c++) wr(2'(c), 3'd0, 32'h0);
    for (int c = 0; c < 3; c++) wr(2'(c), 3'd5, 32'h1);
    wr(2'd3, 3'd0, 32'h1);
    addr = {2'd2, 3'd3};
    #1;
    chk("R10 pair zero", tbase, 32'd0);
    chk("R10 ch2 zero", rdata, 32'd0);
    @(negedge clk);
    #1;
    chk("R10 pair lockstep", tbase, 32'h0001_0001);
    chk("R10 ch2 lockstep", rdata, 32'd1);
    rd(2'd0, 3'd4, v); chk("R10 enable kept", v & 32'h1, 32'd1);

    // R11 R12 R6 chaining and native wide counter
    do_reset();
    wr(2'd0, 3'd0, 32'h1);
    wr(2'd0, 3'd1, 32'h0);
    wr(2'd0, 3'd2, 32'h8000);
    wr(2'd1, 3'd0, 32'h3);
    wr(2'd3, 3'd1, 32'h1);
    wr(2'd0, 3'd5, 32'h1);
    wr(2'd1, 3'd5, 32'h1);
    wr(2'd3, 3'd0, 32'h1);
    rd(2'd3, 3'd1, v); chk("R11 chain readback", v, 32'd1);
    @(negedge clk) tick_fast = 1'b1;
    repeat (65541) @(negedge clk);
    tick_fast = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R11 chained timebase", tbase, 32'h0001_0005);
    chk("R12 native timebase", tbase32, 32'h0001_0005);
    rd(2'd0, 3'd3, v);
    chk("R6 ch0 wrapped", v, 32'd5);
    chk("R12 native count", rdata32, 32'd65541);
    rd(2'd3, 3'd2, v); chk("R11 timebase register", v, 32'h0001_0005);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (190000) @(posedge clk);
        timeout = 1'b1;
      end
    join_any
    disable fork;
    if (timeout) begin
      checks++;
      failures++;
      $display("FAIL watchdog all-requirements act=hung exp=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule